// File: doc/BRIEF.md
# Write-Drain Bus Turnaround Controller

This block decides, cycle by cycle, whether a memory data bus shared by reads and writes serves a read or a write. Writes wait in an external buffer whose occupancy is reported to the block. Reads normally have priority. Writes are held back while reads are pending, until the buffer fills to a programmable high mark. The block then enters a drain mode and issues writes back to back. The drain mode ends when occupancy falls to a programmable low mark. When no read is waiting, buffered writes go out on their own, without entering drain mode.

Each change of bus direction costs a programmable number of idle cycles. During those cycles a turnaround flag is raised and no grant is given. The grants are single-cycle strobes. Each one tells the surrounding scheduler to issue one read or one write in that cycle. The block also drives a ready flag that stalls new writes when the buffer is full.

Top module: `wdrain_turn_ctrl`

## Requirements
- R1: After reset, drain_mode, bus_turn, rd_grant and wr_grant are all 0 and the bus faces the read direction.
- R2: While reads are pending (rd_empty=0) and drain_mode=0, once the bus faces reads, rd_grant is 1 in every cycle.
- R3: While drain_mode=0 and rd_empty=0, wr_grant stays 0 whatever the occupancy, including the cycle in which occupancy first reaches hi_mark.
- R4: drain_mode rises in the cycle after a clock edge that sees wr_count >= hi_mark. It stays 1 while wr_count > lo_mark, and falls after the edge that sees wr_count <= lo_mark.
- R5: While drain_mode=1 and outside a turnaround, wr_grant is 1 in every cycle and rd_grant is 0, even with reads pending.
- R6: With rd_empty=1 and wr_count != 0, writes are granted while drain_mode stays 0.
- R7: A change of direction gives exactly turn_cycles consecutive cycles with bus_turn=1 and no grant. The first grant in the new direction comes in the following cycle. With turn_cycles=0, the grant in the new direction comes in the same cycle as the change.
- R8: rd_grant and wr_grant are never 1 in the same cycle, and wr_grant is 0 whenever wr_count is 0.
- R9: wr_ready is 0 exactly when wr_count equals the buffer depth DEPTH (8 by default).
- R10: lo_mark must be strictly below hi_mark; the block assumes this of its inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_empty | input | 1 | 1 when no read is waiting |
| wr_count | input | $clog2(DEPTH+1) | Number of buffered writes |
| hi_mark | input | $clog2(DEPTH+1) | Occupancy that starts drain mode |
| lo_mark | input | $clog2(DEPTH+1) | Occupancy that ends drain mode |
| turn_cycles | input | $clog2(MAX_TURN+1) | Idle cycles per direction change |
| drain_mode | output | 1 | Write drain mode active |
| bus_turn | output | 1 | Bus idle for turnaround |
| rd_grant | output | 1 | One-cycle read issue strobe |
| wr_grant | output | 1 | One-cycle write issue strobe |
| wr_ready | output | 1 | Buffer can accept a write |

## Verification
Drain entry and a turnaround already in progress can fall in the same cycle. The bench sets this up in three steps. It grants an opportunistic write, then makes reads pending so the bus starts turning back toward reads. One cycle into that gap it raises occupancy to the high mark. The expected result is that the read-bound gap runs to its end and a second full gap toward writes follows, with no read grant. The bench checks that the first write grant comes exactly two turnaround lengths after the reversal began. It also checks that the drain exit and the read-bound gap follow each other exactly when occupancy reaches the low mark.

// File: rtl/wdrain_pkg.sv
package wdrain_pkg;
   typedef enum logic {
      BUS_RD = 1'b0,
      BUS_WR = 1'b1
   } bus_dir_e;
endpackage

// File: rtl/wdrain_hyst.sv
module wdrain_hyst #(
   parameter int CW = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [CW-1:0] wr_count,
   input  logic [CW-1:0] hi_mark,
   input  logic [CW-1:0] lo_mark,
   output logic          drain
);
   logic drain_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         drain_q <= 1'b0;
      end else if (!drain_q && (wr_count >= hi_mark)) begin
         drain_q <= 1'b1;
      end else if (drain_q && (wr_count <= lo_mark)) begin
         drain_q <= 1'b0;
      end
   end

   assign drain = drain_q;

   // R4: entry and exit of the drain mode
   a_r4_enter: assert property (@(posedge clk) disable iff (!rst_n)
      (!drain_q && wr_count >= hi_mark) |=> drain_q);
   a_r4_exit: assert property (@(posedge clk) disable iff (!rst_n)
      (drain_q && wr_count <= lo_mark) |=> !drain_q);
   a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (drain_q && wr_count > lo_mark) |=> drain_q);
endmodule

// File: rtl/wdrain_turn.sv
module wdrain_turn
   import wdrain_pkg::*;
#(
   parameter int MAX_TURN = 15,
   parameter int TW       = (MAX_TURN < 1) ? 1 : $clog2(MAX_TURN + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          want_rd,
   input  logic          want_wr,
   input  logic [TW-1:0] turn_cycles,
   output logic          rd_grant,
   output logic          wr_grant,
   output logic          bus_turn
);
   bus_dir_e dir_q;
   logic     demand;
   logic     mismatch;

   assign demand   = want_rd | want_wr;
   assign mismatch = demand && ((want_wr ? BUS_WR : BUS_RD) != dir_q);

   generate
      if (MAX_TURN == 0) begin : g_free
         // switching costs nothing: direction follows demand at once
         always_ff @(posedge clk) begin
            if (!rst_n)        dir_q <= BUS_RD;
            else if (mismatch) dir_q <= want_wr ? BUS_WR : BUS_RD;
         end
         assign bus_turn = 1'b0;
         assign wr_grant = want_wr;
         assign rd_grant = want_rd;
      end else begin : g_gap
         logic [TW-1:0] gap_q;
         logic          in_gap;
         logic          switch_now;
         logic          start_gap;
         logic          grant_ok;
         bus_dir_e      eff_dir;

         assign in_gap     = (gap_q != '0);
         assign switch_now = !in_gap && mismatch;
         assign start_gap  = switch_now && (turn_cycles != '0);
         assign eff_dir    = switch_now ? (want_wr ? BUS_WR : BUS_RD) : dir_q;
         assign grant_ok   = !in_gap && !start_gap && demand;
         assign wr_grant   = grant_ok && (eff_dir == BUS_WR);
         assign rd_grant   = grant_ok && (eff_dir == BUS_RD);
         assign bus_turn   = in_gap || start_gap;

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               dir_q <= BUS_RD;
               gap_q <= '0;
            end else begin
               if (switch_now) dir_q <= want_wr ? BUS_WR : BUS_RD;
               if (start_gap)   gap_q <= turn_cycles - 1'b1;
               else if (in_gap) gap_q <= gap_q - 1'b1;
            end
         end

         // R7: a running gap counts down by one and keeps the direction
         a_r7_gap_step: assert property (@(posedge clk) disable iff (!rst_n)
            in_gap |=> (gap_q == $past(gap_q) - 1'b1) && (dir_q == $past(dir_q)));
      end
   endgenerate

   // R7: no issue while the bus turns
   a_r7_quiet_turn: assert property (@(posedge clk) disable iff (!rst_n)
      bus_turn |-> (!rd_grant && !wr_grant));
endmodule

// File: rtl/wdrain_turn_ctrl.sv
module wdrain_turn_ctrl #(
   parameter int DEPTH    = 8,
   parameter int MAX_TURN = 15,
   parameter int CW       = $clog2(DEPTH + 1),
   parameter int TW       = (MAX_TURN < 1) ? 1 : $clog2(MAX_TURN + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          rd_empty,
   input  logic [CW-1:0] wr_count,
   input  logic [CW-1:0] hi_mark,
   input  logic [CW-1:0] lo_mark,
   input  logic [TW-1:0] turn_cycles,
   output logic          drain_mode,
   output logic          bus_turn,
   output logic          rd_grant,
   output logic          wr_grant,
   output logic          wr_ready
);
   localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("wdrain_turn_ctrl: DEPTH must be at least 2");
      end
      if (MAX_TURN < 0) begin : g_bad_turn
         $error("wdrain_turn_ctrl: MAX_TURN must not be negative");
      end
   endgenerate

   logic have_wr;
   logic want_wr;
   logic want_rd;

   wdrain_hyst #(.CW(CW)) u_hyst (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_count (wr_count),
      .hi_mark  (hi_mark),
      .lo_mark  (lo_mark),
      .drain    (drain_mode)
   );

   assign have_wr = (wr_count != '0);
   assign want_wr = have_wr && (drain_mode || rd_empty);
   assign want_rd = !rd_empty && !drain_mode;

   wdrain_turn #(.MAX_TURN(MAX_TURN), .TW(TW)) u_turn (
      .clk         (clk),
      .rst_n       (rst_n),
      .want_rd     (want_rd),
      .want_wr     (want_wr),
      .turn_cycles (turn_cycles),
      .rd_grant    (rd_grant),
      .wr_grant    (wr_grant),
      .bus_turn    (bus_turn)
   );

   assign wr_ready = (wr_count < FULL_CNT);

   // R8: one grant at a time, never a write from an empty buffer
   a_r8_one_grant: assert property (@(posedge clk) disable iff (!rst_n)
      !(rd_grant && wr_grant));
   a_r8_no_empty_wr: assert property (@(posedge clk) disable iff (!rst_n)
      wr_grant |-> (wr_count != '0));
   // R3: reads pending and not draining: no write
   a_r3_rd_first: assert property (@(posedge clk) disable iff (!rst_n)
      (!drain_mode && !rd_empty) |-> !wr_grant);
   // R5: draining: no read
   a_r5_no_rd_drain: assert property (@(posedge clk) disable iff (!rst_n)
      drain_mode |-> !rd_grant);
   // R10: threshold ordering expected from the inputs
   a_r10_marks: assert property (@(posedge clk) disable iff (!rst_n)
      lo_mark < hi_mark);
endmodule

// File: tb/wdrain_turn_ctrl_test.sv
module wdrain_turn_ctrl_test;
   localparam int DEPTH    = 8;
   localparam int MAX_TURN = 15;
   localparam int CW       = $clog2(DEPTH + 1);
   localparam int TW       = $clog2(MAX_TURN + 1);

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          rd_empty = 1'b1;
   logic [CW-1:0] wr_count = '0;
   logic [CW-1:0] hi_mark = CW'(6);
   logic [CW-1:0] lo_mark = CW'(2);
   logic [TW-1:0] turn_cycles = TW'(4);
   logic          drain_mode, bus_turn, rd_grant, wr_grant, wr_ready;

   int checks = 0;
   int errors = 0;

   always #5 clk = ~clk;

   wdrain_turn_ctrl #(.DEPTH(DEPTH), .MAX_TURN(MAX_TURN)) uut (
      .clk(clk), .rst_n(rst_n), .rd_empty(rd_empty), .wr_count(wr_count),
      .hi_mark(hi_mark), .lo_mark(lo_mark), .turn_cycles(turn_cycles),
      .drain_mode(drain_mode), .bus_turn(bus_turn), .rd_grant(rd_grant),
      .wr_grant(wr_grant), .wr_ready(wr_ready)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic step();
      @(negedge clk);
      #1;
   endtask

   task automatic drive(input bit rde, input int cnt);
      @(negedge clk);
      rd_empty = rde;
      wr_count = CW'(cnt);
      #1;
   endtask

   // counts idle cycles from the current sample up to the first target grant
   task automatic measure(input bit tgt_wr, input string req, output int idle);
      bit other = 0;
      idle = 0;
      for (int i = 0; i < 40; i++) begin
         if (tgt_wr ? wr_grant : rd_grant) break;
         if (tgt_wr ? rd_grant : wr_grant) other = 1;
         idle++;
         step();
      end
      chk(!other, {req, " wrong-direction grant"}, int'(other), 0);
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      rd_empty = 1'b1;
      wr_count = '0;
      repeat (3) step();
      chk(!drain_mode && !bus_turn && !rd_grant && !wr_grant, "R1 reset outputs",
          {drain_mode, bus_turn, rd_grant, wr_grant}, 0);
      @(negedge clk);
      rst_n = 1'b1;
      rd_empty = 1'b0;
      #1;
      // bus faces reads after reset, so the first read is granted at once
      chk(rd_grant && !bus_turn, "R1 read direction after reset", rd_grant, 1);
   endtask

   task automatic t_reads();
      int n = 0;
      for (int i = 0; i < 5; i++) begin
         drive(0, 3);
         if (rd_grant && !wr_grant) n++;
      end
      chk(n == 5, "R2 back-to-back reads", n, 5);
      chk(!wr_grant, "R3 write held below high mark", wr_grant, 0);
   endtask

   task automatic t_turn();
      int idle;
      turn_cycles = TW'(4);
      drive(1, 3);
      chk(bus_turn, "R7 turnaround flag at switch", bus_turn, 1);
      measure(1, "R7", idle);
      chk(idle == 4, "R7 read-to-write gap", idle, 4);
      chk(!drain_mode, "R6 opportunistic write without drain", drain_mode, 0);
      step();
      chk(wr_grant && !drain_mode, "R6 writes continue while reads idle", wr_grant, 1);
      turn_cycles = TW'(0);
      drive(0, 3);
      chk(rd_grant && !bus_turn, "R7 zero-gap switch grants at once", rd_grant, 1);
      drive(1, 0);
      chk(!wr_grant && !rd_grant, "R8 no write from empty buffer", wr_grant, 0);
      drive(0, 0);
      chk(rd_grant, "R7 zero-gap back to reads", rd_grant, 1);
   endtask

   task automatic t_drain();
      int idle;
      int grants = 0;
      int cnt = 6;
      turn_cycles = TW'(2);
      drive(0, 5);
      drive(0, 6);
      chk(rd_grant && !wr_grant && !drain_mode, "R3 crossing cycle still reads",
          wr_grant, 0);
      step();
      chk(drain_mode, "R4 drain entered one cycle later", drain_mode, 1);
      measure(1, "R5", idle);
      chk(idle == 2, "R7 gap into drain", idle, 2);
      for (int i = 0; i < 10; i++) begin
         if (!(wr_grant && drain_mode)) break;
         grants++;
         cnt--;
         wr_count = CW'(cnt);
         step();
      end
      chk(grants == 4, "R5 writes drained back to back down to low mark", grants, 4);
      chk(!drain_mode, "R4 drain left at low mark", drain_mode, 1'b0);
      measure(0, "R4", idle);
      chk(idle == 2, "R7 gap back to reads", idle, 2);
   endtask

   task automatic t_overlap();
      int idle;
      turn_cycles = TW'(4);
      drive(1, 3);
      measure(1, "R7", idle);
      drive(0, 3);
      chk(bus_turn && !rd_grant, "R7 read-bound gap started", bus_turn, 1);
      step();
      wr_count = CW'(6);
      measure(1, "R5", idle);
      chk(idle == 7, "R5 drain during gap: two full gaps", idle + 1, 8);
      chk(drain_mode, "R4 drain set during overlap", drain_mode, 1);
      // leave drain for the next test
      drive(1, 0);
      step();
   endtask

   task automatic t_ready();
      drive(1, DEPTH);
      chk(!wr_ready, "R9 full buffer stalls writes", wr_ready, 0);
      drive(1, DEPTH - 1);
      chk(wr_ready, "R9 one slot free", wr_ready, 1);
      drive(1, 0);
      chk(wr_ready, "R9 empty buffer ready", wr_ready, 1);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      t_reset();
      t_reads();
      t_turn();
      t_drain();
      t_overlap();
      t_ready();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule